// File: doc/BRIEF.md
# Lookahead Adder with Logic Results

This block is a 16-bit datapath unit that adds or subtracts two operands, or returns their bitwise AND or OR. All carries come from a flat lookahead network. Each bit first forms a generate term (a AND b) and a propagate term (a OR b). Every carry is then an OR of AND chains over those terms, so no carry waits on a lower carry. The generate and propagate vectors double as the AND and OR results, so the logical functions add no extra gates.

Subtraction inverts operand B and drives the carry-in to one, which computes A + ~B + 1. A registered wrapper samples the operands and function select on one clock edge. The result and carry-out appear on the next edge. The carry-out is meaningful only for add and subtract.

Top module: `pc_alu_top`

## Requirements
- R1: With func_i = 2'b00 (ADD), res_o equals (a_i + b_i) mod 2^16, and cout_o equals bit 16 of the 17-bit sum.
- R2: With func_i = 2'b01 (SUB), res_o equals (a_i - b_i) mod 2^16, and cout_o equals bit 16 of a_i + ~b_i + 1, so cout_o is 1 exactly when a_i >= b_i (unsigned).
- R3: With func_i = 2'b10 (AND), res_o equals a_i & b_i and cout_o is 0.
- R4: With func_i = 2'b11 (OR), res_o equals a_i | b_i and cout_o is 0.
- R5: Every carry is correct across a full-length propagate chain. For example, 0xFFFF + 0x0001 gives 0x0000 with cout_o = 1, and 0x8000 + 0x8000 gives 0x0000 with cout_o = 1.
- R6: The outputs change exactly one clock edge after the inputs are sampled. The outputs present that cycle's result, with no further delay.
- R7: While rst_ni is low, res_o and cout_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B |
| func_i | input | 2 | Function: 00 add, 01 subtract, 10 AND, 11 OR |
| res_o | output | 16 | Registered result |
| cout_o | output | 1 | Registered carry-out (add and subtract only) |

## Verification
A wrong term in the carry network shows up as a flipped result bit one cycle after the operands are applied. It appears only for operand pairs whose carry chain passes through the faulty position. For that reason the directed cases include full-length propagate chains, isolated generates at the top bit, and subtract cases around equal operands.

A swapped generate or propagate vector shows up at once in the AND and OR results. A stuck carry-in shows up as an off-by-one in subtraction. Every case is compared against a plain arithmetic model computed in the bench.

// File: rtl/pc_alu_pkg.sv
package pc_alu_pkg;
  localparam int unsigned WIDTH = 16;
  typedef enum logic [1:0] {
    FN_ADD = 2'b00,
    FN_SUB = 2'b01,
    FN_AND = 2'b10,
    FN_OR  = 2'b11
  } alu_fn_e;
endpackage

// File: rtl/pc_gp_stage.sv
module pc_gp_stage #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         inv_b_i,
  output logic [W-1:0] bx_o,
  output logic [W-1:0] g_o,
  output logic [W-1:0] p_o
);
  always_comb begin
    bx_o = inv_b_i ? ~b_i : b_i;
    g_o  = a_i & bx_o;
    p_o  = a_i | bx_o;
  end
endmodule

// File: rtl/pc_carry_net.sv
// Flat lookahead: c[i+1] = g[i] | p[i]g[i-1] | ... | p[i..0]cin
module pc_carry_net #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] g_i,
  input  logic [W-1:0] p_i,
  input  logic         cin_i,
  output logic [W:0]   c_o
);
  assign c_o[0] = cin_i;
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [i+1:0] terms;
    for (genvar j = 0; j <= i; j++) begin : g_term
      // g[j] propagated through p[j+1..i]
      if (j == i) begin : g_top
        assign terms[j] = g_i[j];
      end else begin : g_chain
        assign terms[j] = g_i[j] & (&p_i[i:j+1]);
      end
    end
    assign terms[i+1] = cin_i & (&p_i[i:0]);
    assign c_o[i+1] = |terms;
  end
endmodule

// File: rtl/pc_alu_core.sv
module pc_alu_core
  import pc_alu_pkg::*;
#(
  parameter int unsigned W = WIDTH
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_fn_e      func_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  logic         sub;
  logic [W-1:0] bx, g, p;
  logic [W:0]   c;

  assign sub = (func_i == FN_SUB);

  pc_gp_stage #(.W(W)) u_gp (
    .a_i(a_i), .b_i(b_i), .inv_b_i(sub), .bx_o(bx), .g_o(g), .p_o(p)
  );

  pc_carry_net #(.W(W)) u_cn (
    .g_i(g), .p_i(p), .cin_i(sub), .c_o(c)
  );

  always_comb begin
    unique case (func_i)
      FN_AND:  begin res_o = g;                 cout_o = 1'b0;  end
      FN_OR:   begin res_o = p;                 cout_o = 1'b0;  end
      default: begin res_o = a_i ^ bx ^ c[W-1:0]; cout_o = c[W]; end
    endcase
  end

  always_comb begin
    AST_CARRY_FIRST: assert (c[1] == (g[0] | (p[0] & sub))); // R5
  end
endmodule

// File: rtl/pc_alu_top.sv
module pc_alu_top
  import pc_alu_pkg::*;
#(
  parameter int unsigned W = WIDTH
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   func_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  logic [W-1:0] res_d;
  logic         cout_d;

  pc_alu_core #(.W(W)) u_core (
    .a_i(a_i), .b_i(b_i), .func_i(alu_fn_e'(func_i)),
    .res_o(res_d), .cout_o(cout_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o  <= '0;
      cout_o <= 1'b0;
    end else begin
      res_o  <= res_d;
      cout_o <= cout_d;
    end
  end

  AST_ADD_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(func_i) == 2'b00) |->
      {cout_o, res_o} == ({1'b0, $past(a_i)} + {1'b0, $past(b_i)})); // R1

  AST_SUB_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(func_i) == 2'b01) |->
      (res_o == W'($past(a_i) - $past(b_i)) && cout_o == ($past(a_i) >= $past(b_i)))); // R2

  AST_AND_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(func_i) == 2'b10) |->
      (res_o == ($past(a_i) & $past(b_i)) && !cout_o)); // R3

  AST_OR_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(func_i) == 2'b11) |->
      (res_o == ($past(a_i) | $past(b_i)) && !cout_o)); // R4

  always_comb begin
    if (!rst_ni) AST_RESET_ZERO: assert (res_o == '0 && !cout_o); // R7
  end
endmodule

// File: tb/pc_alu_top_bench.sv
`timescale 1ns/1ps
module pc_alu_top_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] a_i = '0, b_i = '0;
  logic [1:0]  func_i = '0;
  logic [15:0] res_o;
  logic        cout_o;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  pc_alu_top u_pc_alu_top (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(string req, logic [16:0] act, logic [16:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [16:0] model(logic [15:0] a, logic [15:0] b, logic [1:0] f);
    logic [16:0] s;
    case (f)
      2'b00: s = {1'b0, a} + {1'b0, b};
      2'b01: s = {1'b0, a} + {1'b0, ~b} + 17'd1;
      2'b10: s = {1'b0, a & b};
      default: s = {1'b0, a | b};
    endcase
    return s;
  endfunction

  // apply at negedge, result after next posedge
  task automatic op(string req, logic [15:0] a, logic [15:0] b, logic [1:0] f);
    @(negedge clk_i);
    a_i = a; b_i = b; func_i = f;
    @(negedge clk_i);
    chk(req, {cout_o, res_o}, model(a, b, f));
  endtask

  task automatic t_reset;
    a_i = 16'hFFFF; b_i = 16'h0001; func_i = 2'b00;
    #12;
    chk("R7", {cout_o, res_o}, 17'h0);
    @(negedge clk_i);
    chk("R7", {cout_o, res_o}, 17'h0);
    rst_ni = 1'b1;
  endtask

  task automatic t_add;
    op("R1", 16'h1234, 16'h4321, 2'b00);
    op("R1", 16'h0000, 16'h0000, 2'b00);
    op("R1", 16'h7FFF, 16'h0001, 2'b00);
  endtask

  task automatic t_sub;
    op("R2", 16'h5000, 16'h1234, 2'b01);
    op("R2", 16'h0000, 16'h0001, 2'b01);
    op("R2", 16'hABCD, 16'hABCD, 2'b01);
    op("R2", 16'h8000, 16'h7FFF, 2'b01);
  endtask

  task automatic t_logic;
    op("R3", 16'hF0F0, 16'h3C3C, 2'b10);
    op("R3", 16'hFFFF, 16'hFFFF, 2'b10);
    op("R4", 16'hF0F0, 16'h0F0C, 2'b11);
    op("R4", 16'h8000, 16'h0000, 2'b11);
  endtask

  task automatic t_chain;
    op("R5", 16'hFFFF, 16'h0001, 2'b00);
    op("R5", 16'h8000, 16'h8000, 2'b00);
    op("R5", 16'hFFFF, 16'hFFFF, 2'b00);
    op("R5", 16'h5555, 16'hAAAB, 2'b00);
    op("R5", 16'h0000, 16'h0000, 2'b01);
    op("R5", 16'hFFFF, 16'h0000, 2'b01);
  endtask

  task automatic t_timing;
    logic [16:0] prev;
    @(negedge clk_i);
    a_i = 16'h0003; b_i = 16'h0004; func_i = 2'b00;
    @(negedge clk_i);
    prev = {cout_o, res_o};
    a_i = 16'h0100; b_i = 16'h0200;
    #1;
    chk("R6", {cout_o, res_o}, prev);
    chk("R6", prev, 17'h00007);
    @(negedge clk_i);
    chk("R6", {cout_o, res_o}, 17'h00300);
  endtask

  task automatic t_random;
    logic [15:0] a, b;
    logic [1:0]  f;
    for (int i = 0; i < 200; i++) begin
      a = 16'($urandom); b = 16'($urandom); f = 2'($urandom);
      op(f == 2'b00 ? "R1" : f == 2'b01 ? "R2" : f == 2'b10 ? "R3" : "R4", a, b, f);
    end
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_logic();
    t_chain();
    t_timing();
    t_random();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog act=running exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule